// File: doc/BRIEF.md
# Gamma Correction LUT Engine

This block applies gamma correction to a stream of 30-bit RGB pixels. Each of the three colour channels is replaced by an entry from its own 1024-entry table of 10-bit values. Each table is indexed by that channel's 10-bit input value. Two entries share one 32-bit table word: the even entry sits in bits [9:0] and the following odd entry sits in bits [25:16].

Software fills the tables through a 64-byte write-only register window. Each component has an index register and a data port. Writing the index register sets the word position. Each data write stores one word at that position and then advances it by one, wrapping from 511 back to 0. All table writes go to a shadow bank. A swap command is held pending until a frame boundary, or until the pixel path is idle, and only then exchanges the shadow and active banks. The lookup therefore never mixes old and new entries within a frame.

The pixel ports use valid/ready handshakes with one register stage. An input is accepted when `pix_in_valid` and `pix_in_ready` are both high. `pix_in_ready` is high whenever the output register is empty or being drained in the same cycle. An output held with `pix_out_ready` low keeps its data stable and blocks new input. The register interface and `frame_start` are plain pins with no handshake.

Top module: `gamma_lut_engine`

## Requirements
- R1: After reset, `pix_out_valid` is low, `pix_in_ready` is high, the control register is 0 (stage disabled, rounding off) and the active bank is the one not written by the first load.
- R2: With the enable bit (control bit 0) clear, an accepted pixel appears unchanged on `pix_out_data` one clock later, whatever the rounding bit (control bit 1) holds.
- R3: With the enable bit set, an input channel value N produces entry N of that channel's table. That entry is bits [9:0] of word N/2 when N is even and bits [25:16] when N is odd. The result appears one clock after acceptance.
- R4: Pixel layout is red [29:20], green [19:10], blue [9:0]. Table 0 maps green, table 1 maps blue and table 2 maps red.
- R5: Register offsets (byte addresses) are: control 0x00; table 0 data 0x04 and index 0x08; table 1 data 0x0C and index 0x10; table 2 data 0x14 and index 0x18; swap 0x1C. A data write stores the word at the current index and increments that index, wrapping from 511 to 0.
- R6: A write to an index register sets that table's next write position to bits [8:0] of the written value.
- R7: Table writes change only the shadow bank; pixel results keep using the active bank until a swap commits.
- R8: Writing 1 in bit 0 of the swap register makes a swap pending. The swap commits at the first later cycle in which `frame_start` is high or the pixel path is idle (no input valid and no output held). A stream that stays busy keeps the old tables until `frame_start`.
- R9: With enable and rounding both set, each table result becomes min(v+2, 1023) with its two low bits cleared. For example, 1022 gives 1020, 513 gives 512 and 3 gives 4.
- R10: While `pix_out_valid` is high and `pix_out_ready` is low, `pix_out_data` stays stable and `pix_in_ready` is low.
- R11: Writes to unmapped or unaligned offsets (for example 0x20, 0x3C, 0x02), and swap writes with bit 0 clear, change neither the control state nor the banks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 6 | Byte offset within the register window |
| reg_wdata | input | 32 | Register write data |
| frame_start | input | 1 | Frame boundary pulse; lets a pending swap commit |
| pix_in_valid | input | 1 | Input pixel valid |
| pix_in_ready | output | 1 | Input pixel accepted when high together with valid |
| pix_in_data | input | 30 | Input pixel, red [29:20], green [19:10], blue [9:0] |
| pix_out_valid | output | 1 | Output pixel valid |
| pix_out_ready | input | 1 | Downstream accepts the output pixel |
| pix_out_data | output | 30 | Corrected pixel, same layout as the input |

## Verification
A wrong index counter or a misplaced table write shows up on the first pixel that addresses the corrupted entry, one clock after acceptance. Only such pixels reveal it, so the bench aims channel values at the words next to the wrap point and at explicitly indexed words. A wrong bank selection, or a swap that commits early or late, changes every enabled result at once. The bench holds the stream busy across a pending swap to observe the exact cycle of the exchange. Hand-off faults appear as output data that changes while the output is stalled, or as a second pixel accepted behind a held one.

// File: rtl/gamma_pkg.sv
package gamma_pkg;

  localparam int COMP_N = 3;

  // register offsets within the 64-byte window
  localparam logic [5:0] OFF_CTRL = 6'h00;
  localparam logic [5:0] OFF_SWAP = 6'h1C;
  localparam logic [5:0] OFF_COMP_BASE = 6'h04;
  localparam logic [5:0] OFF_COMP_STEP = 6'h08;

  typedef struct packed {
    logic rnd;
    logic en;
  } ctrl_t;

  // data port offset for component c; its index register sits 4 bytes above
  function automatic logic [5:0] data_off(input int c);
    return OFF_COMP_BASE + OFF_COMP_STEP * 6'(c);
  endfunction

endpackage

// File: rtl/gamma_reg_decode.sv
module gamma_reg_decode
  import gamma_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [1:0]          wbits,
  output ctrl_t               ctrl,
  output logic [COMP_N-1:0]   data_we,
  output logic [COMP_N-1:0]   idx_we,
  output logic                swap_req
);

  logic mapped;

  always_comb begin
    data_we  = '0;
    idx_we   = '0;
    swap_req = 1'b0;
    mapped   = 1'b0;
    if (wr_en) begin
      for (int c = 0; c < COMP_N; c++) begin
        if (addr == data_off(c)) begin
          data_we[c] = 1'b1;
          mapped     = 1'b1;
        end
        if (addr == data_off(c) + 6'h04) begin
          idx_we[c] = 1'b1;
          mapped    = 1'b1;
        end
      end
      if (addr == OFF_SWAP) begin
        swap_req = wbits[0];
        mapped   = 1'b1;
      end
      if (addr == OFF_CTRL) mapped = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      ctrl <= '0;
    else if (wr_en && addr == OFF_CTRL)
      ctrl <= ctrl_t'(wbits);
  end

  // R11
  unmapped_write_no_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !mapped) |=> $stable(ctrl));

  // R5
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({data_we, idx_we, swap_req}));

endmodule

// File: rtl/gamma_bank_ctrl.sv
module gamma_bank_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic swap_req,
  input  logic frame_start,
  input  logic idle,
  output logic active_bank
);

  logic pending;
  logic commit;

  assign commit = pending && (frame_start || idle);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending     <= 1'b0;
      active_bank <= 1'b0;
    end else begin
      pending     <= (pending && !commit) || swap_req;
      active_bank <= active_bank ^ commit;
    end
  end

  // R8
  no_swap_without_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pending |=> $stable(active_bank));

  // R8
  busy_stream_holds_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !frame_start && !idle) |=> $stable(active_bank));

endmodule

// File: rtl/gamma_table.sv
module gamma_table #(
  parameter int ENTRY_W  = 10,
  parameter int HALF_OFS = 16,
  localparam int WORDS   = (1 << ENTRY_W) / 2,
  localparam int IDX_W   = ENTRY_W - 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               data_we,
  input  logic               idx_we,
  input  logic [IDX_W-1:0]   idx_val,
  input  logic [ENTRY_W-1:0] lo_val,
  input  logic [ENTRY_W-1:0] hi_val,
  input  logic               wr_bank,
  input  logic               rd_bank,
  input  logic [ENTRY_W-1:0] rd_entry,
  output logic [ENTRY_W-1:0] rd_value
);

  logic [2*ENTRY_W-1:0] mem [2][WORDS];
  logic [IDX_W-1:0]     wr_idx;
  logic [2*ENTRY_W-1:0] rd_word;

  always_ff @(posedge clk) begin
    if (!rst_n)
      wr_idx <= '0;
    else if (idx_we)
      wr_idx <= idx_val;
    else if (data_we)
      wr_idx <= wr_idx + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (data_we)
      mem[wr_bank][wr_idx] <= {hi_val, lo_val};
  end

  assign rd_word  = mem[rd_bank][rd_entry[ENTRY_W-1:1]];
  assign rd_value = rd_entry[0] ? rd_word[2*ENTRY_W-1:ENTRY_W] : rd_word[ENTRY_W-1:0];

  // R5
  index_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we && !idx_we && wr_idx == IDX_W'(WORDS - 1)) |=> wr_idx == '0);

  // R6
  index_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_we |=> wr_idx == $past(idx_val));

  // R7
  shadow_only_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_we |-> wr_bank != rd_bank);

endmodule

// File: rtl/gamma_lut_engine.sv
module gamma_lut_engine
  import gamma_pkg::*;
#(
  parameter int ENTRY_W  = 10,
  parameter int ADDR_W   = 6,
  parameter int HALF_OFS = 16,
  localparam int PIX_W   = 3 * ENTRY_W,
  localparam int IDX_W   = ENTRY_W - 1,
  localparam int DROP    = ENTRY_W - 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic              frame_start,
  input  logic              pix_in_valid,
  output logic              pix_in_ready,
  input  logic [PIX_W-1:0]  pix_in_data,
  output logic              pix_out_valid,
  input  logic              pix_out_ready,
  output logic [PIX_W-1:0]  pix_out_data
);

  ctrl_t             ctrl;
  logic [COMP_N-1:0] data_we;
  logic [COMP_N-1:0] idx_we;
  logic              swap_req;
  logic              active_bank;
  logic              idle;
  logic              in_fire;
  logic [PIX_W-1:0]  mapped;
  logic              unused_wdata_bits;

  assign unused_wdata_bits = ^{reg_wdata[31:HALF_OFS+ENTRY_W], reg_wdata[HALF_OFS-1:ENTRY_W]};

  // keep 8 significant bits: add half an LSB of the kept width, saturate, clear the rest
  function automatic logic [ENTRY_W-1:0] round_keep8(input logic [ENTRY_W-1:0] v);
    logic [ENTRY_W:0] s;
    s = {1'b0, v} + (ENTRY_W+1)'(1 << (DROP - 1));
    if (s[ENTRY_W]) s = {1'b0, {ENTRY_W{1'b1}}};
    return {s[ENTRY_W-1:DROP], {DROP{1'b0}}};
  endfunction

  function automatic int chan_lsb(input int c);
    return (c == 0) ? ENTRY_W : (c == 1) ? 0 : 2 * ENTRY_W;
  endfunction

  gamma_reg_decode #(.ADDR_W(ADDR_W)) u_decode (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_wr_en),
    .addr     (reg_addr),
    .wbits    (reg_wdata[1:0]),
    .ctrl     (ctrl),
    .data_we  (data_we),
    .idx_we   (idx_we),
    .swap_req (swap_req)
  );

  assign idle = !pix_in_valid && !pix_out_valid;

  gamma_bank_ctrl u_bank (
    .clk         (clk),
    .rst_n       (rst_n),
    .swap_req    (swap_req),
    .frame_start (frame_start),
    .idle        (idle),
    .active_bank (active_bank)
  );

  for (genvar c = 0; c < COMP_N; c++) begin : g_comp
    localparam int LSB = chan_lsb(c);
    logic [ENTRY_W-1:0] raw;
    logic [ENTRY_W-1:0] lut;

    assign raw = pix_in_data[LSB +: ENTRY_W];

    gamma_table #(.ENTRY_W(ENTRY_W), .HALF_OFS(HALF_OFS)) u_table (
      .clk      (clk),
      .rst_n    (rst_n),
      .data_we  (data_we[c]),
      .idx_we   (idx_we[c]),
      .idx_val  (reg_wdata[IDX_W-1:0]),
      .lo_val   (reg_wdata[ENTRY_W-1:0]),
      .hi_val   (reg_wdata[HALF_OFS +: ENTRY_W]),
      .wr_bank  (~active_bank),
      .rd_bank  (active_bank),
      .rd_entry (raw),
      .rd_value (lut)
    );

    assign mapped[LSB +: ENTRY_W] = !ctrl.en ? raw : (ctrl.rnd ? round_keep8(lut) : lut);
  end

  assign pix_in_ready = !pix_out_valid || pix_out_ready;
  assign in_fire      = pix_in_valid && pix_in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n)
      pix_out_valid <= 1'b0;
    else
      pix_out_valid <= in_fire || (pix_out_valid && !pix_out_ready);
  end

  always_ff @(posedge clk) begin
    if (in_fire) pix_out_data <= mapped;
  end

  // R10
  stall_holds_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_out_valid && !pix_out_ready) |=> (pix_out_valid && $stable(pix_out_data)));

  // R2
  accept_gives_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire |=> pix_out_valid);

  // R2
  bypass_unchanged_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && !ctrl.en) |=> pix_out_data == $past(pix_in_data));

  // R9
  rounded_low_bits_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && ctrl.en && ctrl.rnd) |=>
      (pix_out_data[DROP-1:0] == '0 && pix_out_data[ENTRY_W +: DROP] == '0 &&
       pix_out_data[2*ENTRY_W +: DROP] == '0));

endmodule

// File: tb/gamma_lut_engine_test.sv
module gamma_lut_engine_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        frame_start = 1'b0;
  logic        pix_in_valid = 1'b0;
  logic        pix_in_ready;
  logic [29:0] pix_in_data = '0;
  logic        pix_out_valid;
  logic        pix_out_ready = 1'b1;
  logic [29:0] pix_out_data;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // bench model: generator per bank (1 = A, 2 = B) plus a few patched entries
  int bank_gen [2] = '{0, 0};
  int act = 0;
  int pb [8]; int pc [8]; int pn [8]; int pv [8];
  int np = 0;

  // {mode[1:0] = {rnd, en}, red, green, blue}
  localparam logic [31:0] VEC [8] = '{
    {2'b01, 10'd0,    10'd0,   10'd0},
    {2'b01, 10'd1023, 10'd1023, 10'd1023},
    {2'b01, 10'd513,  10'd5,   10'd6},
    {2'b00, 10'd682,  10'd682, 10'd682},
    {2'b11, 10'd1000, 10'd3,   10'd1023},
    {2'b10, 10'd17,   10'd300, 10'd999},
    {2'b11, 10'd341,  10'd341, 10'd341},
    {2'b01, 10'd1022, 10'd511, 10'd512}
  };

  gamma_lut_engine uut (
    .clk (clk), .rst_n (rst_n), .reg_wr_en (reg_wr_en), .reg_addr (reg_addr),
    .reg_wdata (reg_wdata), .frame_start (frame_start), .pix_in_valid (pix_in_valid),
    .pix_in_ready (pix_in_ready), .pix_in_data (pix_in_data), .pix_out_valid (pix_out_valid),
    .pix_out_ready (pix_out_ready), .pix_out_data (pix_out_data)
  );

  always #10 clk = ~clk;

  function automatic int gen_val(input int g, input int c, input int n);
    if (g == 1) return (n * 7 + c * 211 + 3) % 1024;
    return (1023 - n) ^ (c * 85);
  endfunction

  function automatic int tab(input int b, input int c, input int n);
    int v;
    v = gen_val(bank_gen[b], c, n);
    for (int k = 0; k < np; k++)
      if (pb[k] == b && pc[k] == c && pn[k] == n) v = pv[k];
    return v;
  endfunction

  function automatic int rnd8(input int v);
    int s;
    s = v + 2;
    if (s > 1023) s = 1023;
    return s & ~3;
  endfunction

  // R4: comp0 = green [19:10], comp1 = blue [9:0], comp2 = red [29:20]
  function automatic logic [29:0] expect_pix(input logic [1:0] mode, input logic [29:0] p);
    int lsb [3] = '{10, 0, 20};
    logic [29:0] r;
    for (int c = 0; c < 3; c++) begin
      int n; int v;
      n = int'(p[lsb[c] +: 10]);
      v = n;
      if (mode[0]) begin
        v = tab(act, c, n);
        if (mode[1]) v = rnd8(v);
      end
      r[lsb[c] +: 10] = 10'(v);
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] actual, input logic [31:0] expected);
    checks++;
    if (actual !== expected) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, actual, expected);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic send(input string req, input logic [1:0] mode, input logic [29:0] p);
    @(negedge clk);
    pix_in_valid = 1'b1; pix_in_data = p;
    @(negedge clk);
    pix_in_valid = 1'b0;
    check(req, {2'b0, pix_out_data}, {2'b0, expect_pix(mode, p)});
  endtask

  task automatic load_bank(input int g);
    int sh;
    sh = 1 - act;
    wr(6'h08, 0); wr(6'h10, 0); wr(6'h18, 0);
    for (int i = 0; i < 512; i++)
      for (int c = 0; c < 3; c++)
        wr(6'(4 + 8 * c), {6'b0, 10'(gen_val(g, c, 2 * i + 1)), 6'b0, 10'(gen_val(g, c, 2 * i))});
    bank_gen[sh] = g;
    for (int k = 0; k < np; k++) if (pb[k] == sh) pb[k] = -1;
  endtask

  task automatic patch(input int c, input int n, input int v);
    pb[np] = 1 - act; pc[np] = c; pn[np] = n; pv[np] = v; np++;
  endtask

  task automatic swap_idle();
    wr(6'h1C, 1);
    @(negedge clk);
    act = 1 - act;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [29:0] p1, p2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 out_valid", {31'b0, pix_out_valid}, 32'd0);
    check("R1 in_ready", {31'b0, pix_in_ready}, 32'd1);
    // R2 bypass straight after reset (control reads 0)
    send("R2 bypass after reset", 2'b00, {10'd900, 10'd17, 10'd512});

    // R5/R8: load first tables, commit on an idle path
    load_bank(1);
    swap_idle();

    // vector walk: R2 / R3 / R4 / R9
    foreach (VEC[i]) begin
      wr(6'h00, {30'b0, VEC[i][31:30]});
      send(VEC[i][30] ? (VEC[i][31] ? "R9 rounded lookup" : "R3 R4 lookup") : "R2 bypass",
           VEC[i][31:30], VEC[i][29:0]);
    end

    // R7: fill the shadow bank, results still from the active one
    wr(6'h00, 32'd1);
    load_bank(2);
    send("R7 shadow load invisible", 2'b01, {10'd100, 10'd200, 10'd300});

    // R8: swap requested while stream is busy; commits only at frame_start
    p1 = {10'd33, 10'd44, 10'd55};
    @(negedge clk);
    pix_in_valid = 1'b1; pix_in_data = p1;
    reg_wr_en = 1'b1; reg_addr = 6'h1C; reg_wdata = 32'd1;
    @(negedge clk);
    reg_wr_en = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R8 pending while busy", {2'b0, pix_out_data}, {2'b0, expect_pix(2'b01, p1)});
    end
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    check("R8 boundary cycle old bank", {2'b0, pix_out_data}, {2'b0, expect_pix(2'b01, p1)});
    act = 1 - act;
    @(negedge clk);
    pix_in_valid = 1'b0;
    check("R8 new bank after frame_start", {2'b0, pix_out_data}, {2'b0, expect_pix(2'b01, p1)});

    // R5 wrap: each index wrapped to 0 after 512 writes
    wr(6'h04, {6'b0, 10'd77, 6'b0, 10'd66});
    patch(0, 0, 66); patch(0, 1, 77);
    // R6 explicit index
    wr(6'h10, 32'd100);
    wr(6'h0C, {6'b0, 10'd513, 6'b0, 10'd1022});
    patch(1, 200, 1022); patch(1, 201, 513);
    wr(6'h18, 32'h0000_FE64);  // bits [8:0] = 100
    wr(6'h14, {6'b0, 10'd3, 6'b0, 10'd514});
    patch(2, 200, 514); patch(2, 201, 3);
    swap_idle();
    send("R5 wrap to word 0, R6 index", 2'b01, {10'd200, 10'd0, 10'd200});
    send("R5 R6 odd halves", 2'b01, {10'd201, 10'd1, 10'd201});
    wr(6'h00, 32'd3);
    send("R9 round saturate", 2'b11, {10'd200, 10'd0, 10'd200});
    send("R9 round odd halves", 2'b11, {10'd201, 10'd1, 10'd201});
    send("R5 neighbour word untouched", 2'b11, {10'd2, 10'd2, 10'd2});

    // R11: ignored writes
    wr(6'h20, 32'hFFFF_FFFF);
    wr(6'h3C, 32'hFFFF_FFFF);
    wr(6'h02, 32'h0000_0000);
    wr(6'h1C, 32'h0000_0002);
    repeat (3) @(negedge clk);
    send("R11 ignored writes", 2'b11, {10'd201, 10'd1, 10'd200});

    // R10 back-pressure in bypass
    wr(6'h00, 32'd0);
    p1 = {10'd1, 10'd2, 10'd3};
    p2 = {10'd4, 10'd5, 10'd6};
    pix_out_ready = 1'b0;
    @(negedge clk);
    pix_in_valid = 1'b1; pix_in_data = p1;
    @(negedge clk);
    pix_in_data = p2;
    check("R10 held valid", {31'b0, pix_out_valid}, 32'd1);
    check("R10 ready low while held", {31'b0, pix_in_ready}, 32'd0);
    @(negedge clk);
    check("R10 data stable", {2'b0, pix_out_data}, {2'b0, p1});
    pix_out_ready = 1'b1;
    @(negedge clk);
    pix_in_valid = 1'b0;
    check("R10 second pixel after release", {2'b0, pix_out_data}, {2'b0, p2});
    @(negedge clk);
    check("R10 drained", {31'b0, pix_out_valid}, 32'd0);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule